// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

The block is a word-addressed scratchpad made of sixteen independent 32-bit banks. Words are interleaved across the banks: the low four bits of a word address choose the bank and the remaining bits choose the row inside that bank. A client presents one wide request for 32 lanes at once. Each lane has an active flag, a word address, a write flag and write data. The block splits the request into a lower half (lanes 0 to 15) and an upper half (lanes 16 to 31) and serves the lower half first.

Inside a half, every bank takes at most one access per two-cycle service slot. Lanes of one half that land on the same bank are queued and served in ascending lane order, one per slot, so a half whose busiest bank receives d lanes takes 2·d cycles. Lanes of different halves never compete with each other. Read data comes back per lane and a one-cycle done pulse ends the request. A running counter adds up the extra slots that conflicts cost, and a clear input resets it.

Top module: `banked_scratchpad`

## Requirements
- R1: A word at address A lives in bank A[3:0] at row A[7:4]; a read of A returns the value most recently written to A.
- R2: A request is taken when req_valid is high in a cycle where busy is low; a request offered while busy is high has no effect on memory, read data or the counter.
- R3: Each bank access fills a two-cycle slot: the bank is driven in the first cycle and the read word is captured in the second.
- R4: The lower half (lanes 0–15) is served completely before the upper half (lanes 16–31); lanes of different halves that share a bank cost no extra slot.
- R5: With dL and dU the largest number of active lanes of the lower and upper half that map to one bank, done is high 2·(dL+dU) cycles after the accepting edge; with no active lane, done is high in the cycle right after acceptance.
- R6: Lanes of one half that share a bank are served in ascending lane order: a read sees writes from lower lanes of the same request, and after several writes to one word the highest lane's data remains.
- R7: Inactive lanes and write lanes return zero on rd_data; rd_data is cleared on acceptance and held from done until the next acceptance.
- R8: On acceptance the conflict counter adds max(dL−1,0)+max(dU−1,0), wrapping modulo 2^16.
- R9: With conf_clr high the counter restarts from zero at the next edge, with that edge's addition (if any) applied to zero.
- R10: busy is high from the cycle after acceptance up to the cycle before done; busy is low whenever done is high.
- R11: A stride-two pattern (lane i reads word 2·i) gives a two-way conflict in each half: done after 8 cycles and the counter grows by 2.
- R12: After reset busy, done, rd_data and the counter are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Offers a new 32-lane request |
| lane_act | input | 32 | Per-lane active flag |
| lane_we | input | 32 | Per-lane write flag (1 = write) |
| lane_addr | input | 256 | Per-lane 8-bit word address, lane i at bits [8i+7:8i] |
| lane_wdata | input | 1024 | Per-lane write data, lane i at bits [32i+31:32i] |
| conf_clr | input | 1 | Clears the conflict counter |
| busy | output | 1 | A request is being served |
| done | output | 1 | One-cycle pulse ending a request |
| rd_data | output | 1024 | Per-lane read data, lane i at bits [32i+31:32i] |
| conf_count | output | 16 | Accumulated extra service slots |

## Verification
The bench builds the block with its default parameters: 32 lanes, 16 banks of 16 rows and a 16-bit counter, so the whole 256-word space can be filled and every bank can be driven up to a sixteen-way conflict in each half. At that size a request with all 32 lanes on one word reaches the longest service time of 64 cycles, while addresses drawn from a 64-word window give frequent mixed two- to four-way conflicts that a behavioural model, running lanes one after another, must match cycle by cycle.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic {
    SP_IDLE  = 1'b0,
    SP_SERVE = 1'b1
  } sp_state_e;

  // extra slots a half costs beyond its first one
  function automatic int unsigned extra_slots(input int unsigned degree);
    return (degree > 0) ? degree - 1 : 0;
  endfunction

endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int ROWS = 16,
  parameter int DW   = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    q        <= mem[row];
    end
  end

endmodule

// File: rtl/sp_pick.sv
module sp_pick #(
  parameter int HALF  = 16,
  parameter int BANKS = 16,
  localparam int BW   = $clog2(BANKS),
  localparam int LW   = $clog2(HALF)
) (
  input  logic [HALF-1:0]    pend,
  input  logic [HALF*BW-1:0] lane_bank,
  output logic [BANKS-1:0]   bank_en,
  output logic [BANKS*LW-1:0] bank_lane,
  output logic [HALF-1:0]    gnt
);

  // lowest pending lane wins each bank
  always_comb begin
    bank_en   = '0;
    bank_lane = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int l = HALF - 1; l >= 0; l--) begin
        if (pend[l] && (int'(lane_bank[l*BW +: BW]) == b)) begin
          bank_en[b]            = 1'b1;
          bank_lane[b*LW +: LW] = LW'(l);
        end
      end
    end
  end

  always_comb begin
    gnt = '0;
    for (int l = 0; l < HALF; l++) begin
      gnt[l] = pend[l] &&
               (int'(bank_lane[int'(lane_bank[l*BW +: BW])*LW +: LW]) == l);
    end
  end

endmodule

// File: rtl/sp_conflict_meter.sv
module sp_conflict_meter #(
  parameter int LANES = 32,
  parameter int BANKS = 16,
  parameter int CW    = 16,
  localparam int HALF = LANES / 2,
  localparam int BW   = $clog2(BANKS),
  localparam int DGW  = $clog2(HALF + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               clr,
  input  logic [LANES-1:0]   act,
  input  logic [LANES*BW-1:0] lane_bank,
  output logic [DGW-1:0]     deg_lo,
  output logic [DGW-1:0]     deg_hi,
  output logic [CW-1:0]      cnt
);

  // largest number of active lanes in one half that share a bank
  function automatic logic [DGW-1:0] half_degree(
    input logic [HALF-1:0]    a,
    input logic [HALF*BW-1:0] bk
  );
    logic [DGW-1:0] best;
    logic [DGW-1:0] cur;
    best = '0;
    for (int b = 0; b < BANKS; b++) begin
      cur = '0;
      for (int l = 0; l < HALF; l++) begin
        if (a[l] && int'(bk[l*BW +: BW]) == b) cur = cur + 1'b1;
      end
      if (cur > best) best = cur;
    end
    return best;
  endfunction

  logic [CW-1:0] inc;

  assign deg_lo = half_degree(act[HALF-1:0], lane_bank[HALF*BW-1:0]);
  assign deg_hi = half_degree(act[LANES-1:HALF], lane_bank[LANES*BW-1:HALF*BW]);
  assign inc    = CW'(sp_pkg::extra_slots(int'(deg_lo)) +
                      sp_pkg::extra_slots(int'(deg_hi)));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= (clr ? '0 : cnt) + (accept ? inc : '0);
  end

  // R9: the counter only moves on a clear or an acceptance
  a_r9_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !accept) |=> $stable(cnt));

  // R8: a half can never exceed its lane count
  always_comb begin
    a_r8_deg_range: assert (int'(deg_lo) <= HALF && int'(deg_hi) <= HALF);
  end

endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES = 32,
  parameter int BANKS = 16,
  parameter int ROWS  = 16,
  parameter int DW    = 32,
  parameter int CW    = 16,
  localparam int AW   = $clog2(BANKS * ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LANES-1:0]    lane_act,
  input  logic [LANES-1:0]    lane_we,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*DW-1:0] lane_wdata,
  input  logic                conf_clr,
  output logic                busy,
  output logic                done,
  output logic [LANES*DW-1:0] rd_data,
  output logic [CW-1:0]       conf_count
);

  import sp_pkg::*;

  localparam int HALF = LANES / 2;
  localparam int BW   = $clog2(BANKS);
  localparam int RW   = $clog2(ROWS);
  localparam int LW   = $clog2(HALF);
  localparam int DGW  = $clog2(HALF + 1);

  sp_state_e           st;
  logic                half_sel;
  logic                slot_ph;
  logic [LANES-1:0]    pend;
  logic [LANES-1:0]    r_we;
  logic [LANES*AW-1:0] r_addr;
  logic [LANES*DW-1:0] r_wdata;
  logic [LANES*DW-1:0] rd_q;
  logic                done_q;

  // named events
  logic accept, issue, retire, half_drained, upper_left, finishing;

  assign accept = req_valid && (st == SP_IDLE);
  assign issue  = (st == SP_SERVE) && !slot_ph;
  assign retire = (st == SP_SERVE) &&  slot_ph;

  // bank number of every incoming lane, for the conflict meter
  logic [LANES*BW-1:0] in_bank;
  always_comb begin
    for (int l = 0; l < LANES; l++) in_bank[l*BW +: BW] = lane_addr[l*AW +: BW];
  end

  logic [DGW-1:0] deg_lo, deg_hi;

  sp_conflict_meter #(
    .LANES(LANES), .BANKS(BANKS), .CW(CW)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .clr      (conf_clr),
    .act      (lane_act),
    .lane_bank(in_bank),
    .deg_lo   (deg_lo),
    .deg_hi   (deg_hi),
    .cnt      (conf_count)
  );

  // view of the half being served
  logic [HALF-1:0]    cur_pend, cur_we;
  logic [HALF*AW-1:0] cur_addr;
  logic [HALF*DW-1:0] cur_wd;
  logic [HALF*BW-1:0] cur_bank;

  always_comb begin
    for (int l = 0; l < HALF; l++) begin
      int idx;
      idx = half_sel ? HALF + l : l;
      cur_pend[l]            = pend[idx];
      cur_we[l]              = r_we[idx];
      cur_addr[l*AW +: AW]   = r_addr[idx*AW +: AW];
      cur_wd[l*DW +: DW]     = r_wdata[idx*DW +: DW];
      cur_bank[l*BW +: BW]   = r_addr[idx*AW +: BW];
    end
  end

  logic [BANKS-1:0]    bank_en;
  logic [BANKS*LW-1:0] bank_lane;
  logic [HALF-1:0]     gnt;

  sp_pick #(.HALF(HALF), .BANKS(BANKS)) u_pick (
    .pend     (cur_pend),
    .lane_bank(cur_bank),
    .bank_en  (bank_en),
    .bank_lane(bank_lane),
    .gnt      (gnt)
  );

  logic [BANKS*DW-1:0] bank_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LW-1:0] sel;
    logic [RW-1:0] row;
    logic          wr;
    logic [DW-1:0] wd;

    always_comb begin
      sel = bank_lane[b*LW +: LW];
      row = cur_addr[int'(sel)*AW + BW +: RW];
      wr  = cur_we[sel];
      wd  = cur_wd[int'(sel)*DW +: DW];
    end

    sp_bank #(.ROWS(ROWS), .DW(DW)) u_bank (
      .clk  (clk),
      .en   (issue && bank_en[b]),
      .we   (wr),
      .row  (row),
      .wdata(wd),
      .q    (bank_q[b*DW +: DW])
    );
  end

  assign half_drained = retire && ((cur_pend & ~gnt) == '0);
  assign upper_left   = |pend[LANES-1:HALF];
  assign finishing    = half_drained && (half_sel || !upper_left);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SP_IDLE;
      half_sel <= 1'b0;
      slot_ph  <= 1'b0;
      pend     <= '0;
      r_we     <= '0;
      r_addr   <= '0;
      r_wdata  <= '0;
      rd_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend     <= lane_act;
        r_we     <= lane_we;
        r_addr   <= lane_addr;
        r_wdata  <= lane_wdata;
        rd_q     <= '0;
        slot_ph  <= 1'b0;
        half_sel <= ~|lane_act[HALF-1:0];
        if (lane_act == '0) done_q <= 1'b1;
        else                st     <= SP_SERVE;
      end else if (issue) begin
        slot_ph <= 1'b1;
      end else if (retire) begin
        slot_ph <= 1'b0;
        for (int l = 0; l < HALF; l++) begin
          if (gnt[l]) begin
            int base;
            int bk;
            base = half_sel ? HALF : 0;
            bk   = int'(cur_bank[l*BW +: BW]);
            if (!cur_we[l]) rd_q[(base + l)*DW +: DW] <= bank_q[bk*DW +: DW];
            pend[base + l] <= 1'b0;
          end
        end
        if (finishing) begin
          st     <= SP_IDLE;
          done_q <= 1'b1;
        end else if (half_drained) begin
          half_sel <= 1'b1;
        end
      end
    end
  end

  assign busy    = (st == SP_SERVE);
  assign done    = done_q;
  assign rd_data = rd_q;

  // R3: every driven slot is followed by its capture cycle with the same grants
  a_r3_slot_pair: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (retire && $stable(gnt)));

  // R4: the upper half is only served once the lower half is drained
  a_r4_half_order: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_sel) |-> (pend[HALF-1:0] == '0));

  // R6: at most one lane per bank in each slot
  a_r6_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ($countones(gnt) == $countones(bank_en)));

  // R10: done never overlaps busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: read data holds while idle and no request is taken
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(rd_data));

endmodule

// File: tb/banked_scratchpad_tb_top.sv
module banked_scratchpad_tb_top;

  localparam int LANES = 32;
  localparam int HALF  = 16;
  localparam int BANKS = 16;
  localparam int ROWS  = 16;
  localparam int DW    = 32;
  localparam int CW    = 16;
  localparam int AW    = 8;
  localparam int WORDS = BANKS * ROWS;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                req_valid;
  logic [LANES-1:0]    lane_act, lane_we;
  logic [LANES*AW-1:0] lane_addr;
  logic [LANES*DW-1:0] lane_wdata;
  logic                conf_clr;
  logic                busy, done;
  logic [LANES*DW-1:0] rd_data;
  logic [CW-1:0]       conf_count;

  always #2 clk = ~clk;

  banked_scratchpad dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .lane_act(lane_act), .lane_we(lane_we), .lane_addr(lane_addr),
    .lane_wdata(lane_wdata), .conf_clr(conf_clr),
    .busy(busy), .done(done), .rd_data(rd_data), .conf_count(conf_count)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // stimulus arrays
  bit          t_act [LANES];
  bit          t_we  [LANES];
  int          t_addr[LANES];
  logic [31:0] t_wd  [LANES];

  function automatic logic [31:0] pat(input int a);
    return 32'hC0DE_0000 | 32'(a);
  endfunction

  task automatic clear_stim();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 0; t_we[l] = 0; t_addr[l] = 0; t_wd[l] = '0;
    end
  endtask

  task automatic pack_stim();
    for (int l = 0; l < LANES; l++) begin
      lane_act[l] = t_act[l];
      lane_we[l]  = t_we[l];
      lane_addr[l*AW +: AW]   = AW'(t_addr[l]);
      lane_wdata[l*DW +: DW]  = t_wd[l];
    end
  endtask

  // offers a request and waits for done; lat counts cycles from the drive
  task automatic issue(output int lat);
    int t0;
    @(negedge clk);
    pack_stim();
    req_valid = 1'b1;
    t0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    lat = cyc - t0;
  endtask

  function automatic logic [31:0] lane_rd(input int l);
    return rd_data[l*DW +: DW];
  endfunction

  // ---------------- behavioural reference ----------------
  logic [31:0] mmem [WORDS];
  logic [31:0] mrd  [LANES];
  int          mleft;
  bit          mdone;
  logic [CW-1:0] mcnt;

  function automatic int model_degree(input int h);
    int cnt [BANKS];
    int best;
    foreach (cnt[b]) cnt[b] = 0;
    best = 0;
    for (int l = h * HALF; l < (h + 1) * HALF; l++) begin
      if (lane_act[l]) begin
        int bk;
        bk = int'(lane_addr[l*AW +: AW]) % BANKS;
        cnt[bk]++;
        if (cnt[bk] > best) best = cnt[bk];
      end
    end
    return best;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mleft = 0; mdone = 0; mcnt = '0;
      foreach (mrd[l]) mrd[l] = '0;
    end else begin
      logic [CW-1:0] base;
      int inc;
      mdone = 0;
      base  = conf_clr ? '0 : mcnt;
      inc   = 0;
      if (mleft == 0 && req_valid) begin
        int d0, d1;
        d0  = model_degree(0);
        d1  = model_degree(1);
        inc = (d0 > 0 ? d0 - 1 : 0) + (d1 > 0 ? d1 - 1 : 0);
        foreach (mrd[l]) mrd[l] = '0;
        for (int l = 0; l < LANES; l++) begin
          if (lane_act[l]) begin
            int a;
            a = int'(lane_addr[l*AW +: AW]);
            if (lane_we[l]) mmem[a] = lane_wdata[l*DW +: DW];
            else            mrd[l]  = mmem[a];
          end
        end
        mleft = 2 * (d0 + d1);
        if (mleft == 0) mdone = 1;
      end else if (mleft > 0) begin
        mleft--;
        if (mleft == 0) mdone = 1;
      end
      mcnt = base + CW'(inc);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R10 busy", 64'(busy), 64'(mleft > 0));
      chk("R5 done", 64'(done), 64'(mdone));
      chk("R8 conf_count", 64'(conf_count), 64'(mcnt));
      if (mleft == 0) begin
        for (int l = 0; l < LANES; l++) begin
          if (rd_data[l*DW +: DW] !== mrd[l]) begin
            chk($sformatf("R6/R7 rd_data lane %0d", l), 64'(rd_data[l*DW +: DW]), 64'(mrd[l]));
          end
        end
        checks++;
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int lat;
    logic [CW-1:0] c0;
    rst_n = 1'b0; req_valid = 1'b0; conf_clr = 1'b0;
    lane_act = '0; lane_we = '0; lane_addr = '0; lane_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R12 busy after reset", 64'(busy), 64'd0);
    chk("R12 done after reset", 64'(done), 64'd0);
    chk("R12 count after reset", 64'(conf_count), 64'd0);
    chk("R12 rd_data after reset", 64'(rd_data == '0), 64'd1);
    rst_n = 1'b1;

    // fill the whole space, consecutive words per lane
    for (int k = 0; k < WORDS / LANES; k++) begin
      clear_stim();
      for (int l = 0; l < LANES; l++) begin
        t_act[l] = 1; t_we[l] = 1; t_addr[l] = k * LANES + l; t_wd[l] = pat(k * LANES + l);
      end
      issue(lat);
      chk("R5 conflict-free latency", 64'(lat), 64'd5);
    end

    // R1: scattered reads with one lane per bank in each half
    clear_stim();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 1; t_addr[l] = (l * 17 + 32) % WORDS;
    end
    issue(lat);
    for (int l = 0; l < LANES; l++) chk("R1 read back", 64'(lane_rd(l)), 64'(pat((l * 17 + 32) % WORDS)));

    // R11: stride two
    c0 = conf_count;
    clear_stim();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 1; t_addr[l] = 2 * l;
    end
    issue(lat);
    chk("R11 stride latency", 64'(lat), 64'd9);
    chk("R11 stride count", 64'(conf_count - c0), 64'd2);
    chk("R11 stride data lane 9", 64'(lane_rd(9)), 64'(pat(18)));

    // R4: same bank in different halves
    c0 = conf_count;
    clear_stim();
    t_act[0] = 1; t_addr[0] = 3;
    t_act[16] = 1; t_addr[16] = 19;
    issue(lat);
    chk("R4 cross-half latency", 64'(lat), 64'd5);
    chk("R4 cross-half count", 64'(conf_count - c0), 64'd0);
    chk("R4 cross-half data", 64'(lane_rd(16)), 64'(pat(19)));

    // R6: every lane writes one word, highest lane remains
    c0 = conf_count;
    clear_stim();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 1; t_we[l] = 1; t_addr[l] = 5; t_wd[l] = 32'(100 + l);
    end
    issue(lat);
    chk("R6 sixteen-way latency", 64'(lat), 64'd65);
    chk("R6 sixteen-way count", 64'(conf_count - c0), 64'd30);
    clear_stim();
    t_act[0] = 1; t_addr[0] = 5;
    t_act[1] = 1; t_we[1] = 1; t_addr[1] = 7; t_wd[1] = 32'hAA;
    t_act[2] = 1; t_addr[2] = 7;
    t_act[3] = 1; t_addr[3] = 23;
    issue(lat);
    chk("R6 highest lane wins", 64'(lane_rd(0)), 64'(100 + 31));
    chk("R6 read sees lower-lane write", 64'(lane_rd(2)), 64'hAA);
    chk("R6 third in bank", 64'(lane_rd(3)), 64'(pat(23)));
    chk("R7 write lane reads zero", 64'(lane_rd(1)), 64'd0);
    chk("R7 inactive lane zero", 64'(lane_rd(4)), 64'd0);

    // R2: a request offered while busy is ignored
    clear_stim();
    t_act[0] = 1; t_addr[0] = 40;
    @(negedge clk);
    pack_stim();
    req_valid = 1'b1;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 1; t_we[l] = 1; t_addr[l] = 64 + l; t_wd[l] = 32'hDEAD;
    end
    pack_stim();
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    clear_stim();
    t_act[0] = 1; t_addr[0] = 64;
    t_act[20] = 1; t_addr[20] = 84;
    issue(lat);
    chk("R2 ignored write lane 0", 64'(lane_rd(0)), 64'(pat(64)));
    chk("R2 ignored write lane 20", 64'(lane_rd(20)), 64'(pat(84)));

    // R5: empty request
    c0 = conf_count;
    clear_stim();
    issue(lat);
    chk("R5 empty latency", 64'(lat), 64'd1);
    chk("R7 empty clears data", 64'(rd_data == '0), 64'd1);
    chk("R8 empty count", 64'(conf_count - c0), 64'd0);

    // R9: clear, alone and together with an acceptance
    @(negedge clk);
    conf_clr = 1'b1;
    @(negedge clk);
    conf_clr = 1'b0;
    chk("R9 clear", 64'(conf_count), 64'd0);
    clear_stim();
    for (int l = 0; l < 4; l++) begin
      t_act[l] = 1; t_addr[l] = 16 * l;
    end
    @(negedge clk);
    pack_stim();
    req_valid = 1'b1; conf_clr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; conf_clr = 1'b0;
    chk("R9 clear with add", 64'(conf_count), 64'd3);
    while (!done) @(negedge clk);

    // mixed traffic in a narrow window
    for (int n = 0; n < 40; n++) begin
      clear_stim();
      for (int l = 0; l < LANES; l++) begin
        t_act[l]  = ($urandom % 4) != 0;
        t_we[l]   = ($urandom % 3) == 0;
        t_addr[l] = int'($urandom % 64);
        t_wd[l]   = $urandom;
      end
      issue(lat);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule